// File: doc/BRIEF.md
# Triggered Fan Tachometer Measurement Unit

This unit times a fan's tach signal when asked to. Software picks one of up to sixteen tach lines by writing a one-hot trigger word, after first writing the word to zero. Once armed, the unit waits for a qualifying edge on the chosen line. It then counts ticks of a divided measurement clock until the next qualifying edge. The tick count is the fan period, in units of the measurement clock.

A qualifying edge is a falling edge, a rising edge or either edge, as the edge mode selects. A programmable window, counted in measurement ticks from the start, limits how long a stuck or stopped fan can hold the unit busy. Software polls the result word: a set completion bit means the count field holds a finished measurement. The host converts the count to a speed.

Top module: `fanTach`

## Requirements
- R1: While reset is asserted, and after it is released, `result` reads all zeros.
- R2: A measurement starts on a clock edge only when all three hold: `trigger` was all zeros in the previous cycle, it now has exactly one bit set, and that bit's channel has its `chanEn` bit at 1. One cycle after the start, `result` reads all zeros.
- R3: A trigger that is ignored leaves `result` unchanged and starts no measurement. A trigger is ignored when it selects a disabled channel, when it has more than one bit set, or when it changes between two non-zero values with no zero word in between.
- R4: The measurement clock ticks once every 4·4^`clkDiv` base cycles: 4, 16, 64 or 256 for `clkDiv` = 0, 1, 2, 3. The tick phase restarts at each start.
- R5: The `edgeMode` encoding is: 2'b00 counts falling edges, 2'b01 counts rising edges, 2'b10 counts both edges, and 2'b11 counts no edge at all, so a measurement in that mode can only end by window expiry.
- R6: Each tach line passes through a two-flop synchronizer. The reported count is the number of ticks in the cycles after the first qualifying edge, up to and including the cycle of the second qualifying edge. For a square wave whose qualifying-edge spacing is a multiple of the tick period, this equals that spacing divided by the tick period.
- R7: If the window of `measUnit` ticks from the start runs out before the second qualifying edge, the measurement ends with status 1 and count 0. A `measUnit` of 0 behaves like 1.
- R8: If the closing edge and window expiry fall in the same cycle, the edge wins and the count is reported.
- R9: Layout of `result`: bit 31 is the completion flag, bits 19:0 hold the count, and bits 30:20 read zero. Whenever bit 31 is clear, the count field reads zero and is not valid.
- R10: A new valid trigger during a measurement drops that measurement and starts over on the new channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tachIn | input | 16 | Raw tach lines, one per channel |
| chanEn | input | 16 | Per-channel permission to be measured |
| trigger | input | 16 | One-hot trigger word; must pass through zero between starts |
| edgeMode | input | 2 | Qualifying edge selection (encoding in R5) |
| clkDiv | input | 2 | Measurement clock prescale code |
| measUnit | input | 16 | Window length in measurement ticks |
| result | output | 32 | Completion flag in bit 31, count in bits 19:0 |

## Verification
The closing tach edge and the last tick of the window can fall in the same cycle, and then one must take precedence. The bench provokes this by locking each start to the tach waveform's phase. It sweeps the start offset over all sixteen positions of a 16-cycle period and the window over three to eight ticks, so some runs put the closing edge exactly on the expiring tick. A behavioural model, compared every clock, judges each outcome and counts those coincidences. The run must see at least one coincidence and must report the count in each of them.

// File: rtl/fanTachPkg.sv
`timescale 1ns/1ps
package fanTachPkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS
  } tachState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic start;     // accept a new measurement
    logic busy;      // a measurement is in progress
    logic armClr;    // first qualifying edge seen, clear tick count
    logic countEn;   // accumulate ticks
    logic finCount;  // close with the tick count
    logic finZero;   // close on window expiry
  } tachStrb_t;

  localparam logic [1:0] EDGE_FALL = 2'b00;
  localparam logic [1:0] EDGE_RISE = 2'b01;
  localparam logic [1:0] EDGE_BOTH = 2'b10;

endpackage

// File: rtl/fanTachCtrl.sv
`timescale 1ns/1ps
module fanTachCtrl
  import fanTachPkg::*;
#(
  parameter int NCH = 16
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [NCH-1:0] trigger,
  input  logic [NCH-1:0] chanEn,
  input  logic           edgeHit,
  input  logic           winExpire,
  output tachStrb_t      strb
);

  logic [NCH-1:0] trigPrev;
  tachState_t     state;
  tachState_t     stateNxt;

  always_comb begin
    strb         = '0;
    stateNxt     = state;
    strb.busy    = (state != ST_IDLE);
    strb.countEn = (state == ST_MEAS);
    strb.start   = (trigPrev == '0) && $onehot(trigger) && (|(trigger & chanEn));
    if (strb.start) begin
      stateNxt = ST_ARM;
    end else if (state == ST_MEAS && edgeHit) begin
      strb.finCount = 1'b1;
      stateNxt      = ST_IDLE;
    end else if (strb.busy && winExpire) begin
      strb.finZero = 1'b1;
      stateNxt     = ST_IDLE;
    end else if (state == ST_ARM && edgeHit) begin
      strb.armClr = 1'b1;
      stateNxt    = ST_MEAS;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPrev <= '0;
      state    <= ST_IDLE;
    end else begin
      trigPrev <= trigger;
      state    <= stateNxt;
    end
  end

endmodule

// File: rtl/fanTachPath.sv
`timescale 1ns/1ps
module fanTachPath
  import fanTachPkg::*;
#(
  parameter int NCH    = 16,
  parameter int CNT_W  = 20,
  parameter int UNIT_W = 16,
  parameter int RES_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    tachIn,
  input  logic [NCH-1:0]    trigger,
  input  logic [1:0]        edgeMode,
  input  logic [1:0]        clkDiv,
  input  logic [UNIT_W-1:0] measUnit,
  input  tachStrb_t         strb,
  output logic              tick,
  output logic              edgeHit,
  output logic              winExpire,
  output logic [RES_W-1:0]  result
);

  localparam int CH_W  = (NCH > 1) ? $clog2(NCH) : 1;
  localparam int DIV_W = 2;
  localparam int PRE_W = 2 + 2 * ((1 << DIV_W) - 1);
  localparam int PAD_W = RES_W - 1 - CNT_W;

  logic [NCH-1:0]    curLvl;
  logic [NCH-1:0]    prvLvl;
  logic [CH_W-1:0]   sel;
  logic [CH_W-1:0]   trigIdx;
  logic [PRE_W-1:0]  presc;
  logic [PRE_W-1:0]  prescTop;
  logic [UNIT_W-1:0] winCnt;
  logic [CNT_W-1:0]  tickCnt;
  logic              lvlNow;
  logic              lvlOld;

  // two-flop synchronizer plus one history flop per line
  for (genvar g = 0; g < NCH; g++) begin : g_sync
    logic [2:0] shReg;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) shReg <= '0;
      else       shReg <= {shReg[1:0], tachIn[g]};
    end
    assign curLvl[g] = shReg[1];
    assign prvLvl[g] = shReg[2];
  end

  always_comb begin
    trigIdx = '0;
    for (int i = 0; i < NCH; i++) begin
      if (trigger[i]) trigIdx = CH_W'(i);
    end
  end

  always_comb begin
    lvlNow = curLvl[sel];
    lvlOld = prvLvl[sel];
    case (edgeMode)
      EDGE_FALL: edgeHit = !lvlNow && lvlOld;
      EDGE_RISE: edgeHit = lvlNow && !lvlOld;
      EDGE_BOTH: edgeHit = lvlNow != lvlOld;
      default:   edgeHit = 1'b0;
    endcase
  end

  assign prescTop  = PRE_W'((32'd4 << {clkDiv, 1'b0}) - 32'd1);
  assign tick      = strb.busy && (presc == prescTop);
  assign winExpire = tick && (({1'b0, winCnt} + 1'b1) >= {1'b0, measUnit});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sel     <= '0;
      presc   <= '0;
      winCnt  <= '0;
      tickCnt <= '0;
      result  <= '0;
    end else if (strb.start) begin
      sel     <= trigIdx;
      presc   <= '0;
      winCnt  <= '0;
      tickCnt <= '0;
      result  <= '0;
    end else begin
      if (strb.busy) begin
        presc <= tick ? '0 : presc + 1'b1;
        if (tick) winCnt <= winCnt + 1'b1;
      end
      if (strb.armClr)                tickCnt <= '0;
      else if (strb.countEn && tick)  tickCnt <= tickCnt + 1'b1;
      if (strb.finCount)     result <= {1'b1, {PAD_W{1'b0}}, tickCnt + CNT_W'(tick)};
      else if (strb.finZero) result <= {1'b1, {(RES_W-1){1'b0}}};
    end
  end

endmodule

// File: rtl/fanTach.sv
`timescale 1ns/1ps
module fanTach
  import fanTachPkg::*;
#(
  parameter int NCH    = 16,
  parameter int CNT_W  = 20,
  parameter int UNIT_W = 16,
  parameter int RES_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NCH-1:0]    tachIn,
  input  logic [NCH-1:0]    chanEn,
  input  logic [NCH-1:0]    trigger,
  input  logic [1:0]        edgeMode,
  input  logic [1:0]        clkDiv,
  input  logic [UNIT_W-1:0] measUnit,
  output logic [RES_W-1:0]  result
);

  tachStrb_t strb;
  logic      tick;
  logic      edgeHit;
  logic      winExpire;

  fanTachCtrl #(.NCH(NCH)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .trigger   (trigger),
    .chanEn    (chanEn),
    .edgeHit   (edgeHit),
    .winExpire (winExpire),
    .strb      (strb)
  );

  fanTachPath #(
    .NCH    (NCH),
    .CNT_W  (CNT_W),
    .UNIT_W (UNIT_W),
    .RES_W  (RES_W)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .tachIn    (tachIn),
    .trigger   (trigger),
    .edgeMode  (edgeMode),
    .clkDiv    (clkDiv),
    .measUnit  (measUnit),
    .strb      (strb),
    .tick      (tick),
    .edgeHit   (edgeHit),
    .winExpire (winExpire),
    .result    (result)
  );

endmodule

// File: rtl/fanTachChk.sv
`timescale 1ns/1ps
module fanTachChk (
  input logic        clk,
  input logic        rstN,
  input logic [31:0] result,
  input logic [1:0]  edgeMode,
  input logic        startStb,
  input logic        busyStb,
  input logic        tick,
  input logic        edgeHit
);

  // R2: a start leaves the result cleared one cycle later
  p_start_clears_r2: assert property (@(posedge clk) disable iff (!rstN)
    startStb |=> (result == 32'h0));

  // R3: with nothing running and nothing starting, the result holds
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!busyStb && !startStb) |=> $stable(result));

  // R4: measurement ticks only happen during a measurement
  p_tick_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    tick |-> busyStb);

  // R5: the reserved mode never qualifies an edge
  p_reserved_mode_r5: assert property (@(posedge clk) disable iff (!rstN)
    (edgeMode == 2'b11) |-> !edgeHit);

  // R7: completion only rises out of a running measurement
  p_done_from_busy_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(result[31]) |-> $past(busyStb));

  // R9: an unfinished result carries no count
  p_invalid_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !result[31] |-> (result[19:0] == 20'h0));

endmodule

bind fanTach fanTachChk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .result   (result),
  .edgeMode (edgeMode),
  .startStb (strb.start),
  .busyStb  (strb.busy),
  .tick     (tick),
  .edgeHit  (edgeHit)
);

// File: tb/fanTach_bench.sv
`timescale 1ns/1ps
module fanTach_bench;

  localparam int NCH = 16;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic [NCH-1:0] chanEn = '0;
  logic [NCH-1:0] trigger = '0;
  logic [NCH-1:0] genMask = '0;
  logic [NCH-1:0] tachIn;
  logic [1:0]     edgeMode = 2'b01;
  logic [1:0]     clkDiv = 2'b00;
  logic [15:0]    measUnit = 16'd1000;
  logic [31:0]    result;

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    finished = 1'b0;
  string curReq = "R1";

  always #4 clk = ~clk;

  // tach waveform source
  int   halfPer = 8;
  int   hCnt = 0;
  logic wave = 1'b0;
  always @(negedge clk) begin
    if (hCnt >= halfPer - 1) begin
      hCnt <= 0;
      wave <= ~wave;
    end else begin
      hCnt <= hCnt + 1;
    end
  end
  assign tachIn = genMask & {NCH{wave}};

  fanTach u_fanTach (
    .clk      (clk),
    .rstN     (rstN),
    .tachIn   (tachIn),
    .chanEn   (chanEn),
    .trigger  (trigger),
    .edgeMode (edgeMode),
    .clkDiv   (clkDiv),
    .measUnit (measUnit),
    .result   (result)
  );

  // behavioural reference model
  int             mState = 0;   // 0 idle, 1 waiting first edge, 2 counting
  int             mSel = 0;
  int             mPresc = 0;
  int             mWin = 0;
  int             mCnt = 0;
  int             mCoinc = 0;
  logic [31:0]    mRes = '0;
  logic [NCH-1:0] mTrigPrev = '0;
  logic [NCH-1:0] d1 = '0, d2 = '0, d3 = '0;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mState = 0; mSel = 0; mPresc = 0; mWin = 0; mCnt = 0;
      mRes = '0; mTrigPrev = '0; d1 = '0; d2 = '0; d3 = '0;
    end else begin
      automatic bit start = (mTrigPrev == '0) && ($countones(trigger) == 1) &&
                            ((trigger & chanEn) != '0);
      automatic bit a = d2[mSel];
      automatic bit b = d3[mSel];
      automatic bit hit = (edgeMode == 2'b00) ? (!a && b) :
                          (edgeMode == 2'b01) ? (a && !b) :
                          (edgeMode == 2'b10) ? (a != b) : 1'b0;
      automatic int dv = 4 << (2 * clkDiv);
      automatic bit busy = (mState != 0);
      automatic bit tk = busy && (mPresc == dv - 1);
      automatic bit ex = tk && (mWin + 1 >= int'(measUnit));
      if (start) begin
        for (int i = 0; i < NCH; i++) if (trigger[i]) mSel = i;
        mState = 1; mPresc = 0; mWin = 0; mCnt = 0; mRes = '0;
      end else if (busy) begin
        if (mState == 2 && hit) begin
          if (ex) mCoinc++;
          mRes = 32'h8000_0000 | (mCnt + (tk ? 1 : 0));
          mState = 0;
        end else if (ex) begin
          mRes = 32'h8000_0000;
          mState = 0;
        end else if (mState == 1 && hit) begin
          mState = 2;
          mCnt = 0;
        end else if (mState == 2 && tk) begin
          mCnt++;
        end
        mPresc = tk ? 0 : mPresc + 1;
        if (tk) mWin++;
      end
      mTrigPrev = trigger;
      d3 = d2; d2 = d1; d1 = tachIn;
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!finished) begin
      checks++;
      if (result !== mRes) begin
        errors++;
        $display("FAIL %s per-cycle result: got %h expected %h", curReq, result, mRes);
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected at most 150000", cycles);
      finish_run();
    end
  end

  task automatic checkVal(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic waitDone(input int lim);
    for (int i = 0; i < lim; i++) begin
      if (result[31]) break;
      @(negedge clk);
    end
  endtask

  task automatic startCh(input int ch);
    trigger = '0;
    @(negedge clk);
    trigger = NCH'(1) << ch;
    @(negedge clk);
    checkVal("R2 cleared after start", result, 32'h0);
  endtask

  task automatic measure(input int ch, input string req, input logic [31:0] exp);
    curReq = req;
    startCh(ch);
    waitDone(6000);
    checkVal(req, result, exp);
  endtask

  initial begin
    logic [31:0] saved;
    repeat (5) @(negedge clk);
    checkVal("R1 in reset", result, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    checkVal("R1 after reset", result, 32'h0);

    chanEn   = 16'h7FFF;
    genMask  = '1;
    halfPer  = 8;
    clkDiv   = 2'd0;
    measUnit = 16'd1000;

    edgeMode = 2'b01;
    measure(3, "R6 rising period 16 div0", 32'h8000_0004);
    edgeMode = 2'b00;
    measure(3, "R5 falling", 32'h8000_0004);
    edgeMode = 2'b10;
    measure(7, "R5 both edges", 32'h8000_0002);
    edgeMode = 2'b01;
    measure(0, "R9 layout channel 0", 32'h8000_0004);

    // prescaler codes
    clkDiv = 2'd1; halfPer = 32;
    measure(1, "R4 div code 1", 32'h8000_0004);
    clkDiv = 2'd2; halfPer = 128; measUnit = 16'd100;
    measure(2, "R4 div code 2", 32'h8000_0004);
    clkDiv = 2'd3; halfPer = 512;
    measure(4, "R4 div code 3", 32'h8000_0004);

    // window expiry
    clkDiv = 2'd0; halfPer = 8;
    edgeMode = 2'b11; measUnit = 16'd6;
    measure(3, "R7 reserved mode times out", 32'h8000_0000);
    measUnit = 16'd0;
    measure(3, "R7 zero window", 32'h8000_0000);
    edgeMode = 2'b01; measUnit = 16'd2;
    measure(3, "R7 short window", 32'h8000_0000);

    // ignored triggers
    measUnit = 16'd1000;
    measure(3, "R6 reference before ignore tests", 32'h8000_0004);
    saved = result;
    curReq = "R3";
    trigger = '0; @(negedge clk);
    trigger = 16'h8000; repeat (40) @(negedge clk);
    checkVal("R3 disabled channel", result, saved);
    trigger = '0; @(negedge clk);
    trigger = 16'h0003; repeat (40) @(negedge clk);
    checkVal("R3 two bits set", result, saved);
    trigger = 16'h0004; repeat (40) @(negedge clk);
    checkVal("R3 no zero between", result, saved);

    // restart mid-measurement
    genMask = 16'h0001; measUnit = 16'd60000;
    curReq = "R10";
    startCh(5);
    repeat (30) @(negedge clk);
    checkVal("R10 first run still busy", result, 32'h0);
    measure(0, "R10 restart on new channel", 32'h8000_0004);

    // closing edge against window expiry
    genMask = '1;
    curReq = "R8";
    for (int u = 3; u <= 8; u++) begin
      measUnit = 16'(u);
      for (int d = 0; d < 16; d++) begin
        trigger = '0;
        @(negedge clk);
        @(posedge wave);
        repeat (d) @(negedge clk);
        trigger = 16'h0002;
        @(negedge clk);
        waitDone(200);
        checks++;
        if (!result[31]) begin
          errors++;
          $display("FAIL R8 sweep completion: got %h expected bit 31 set", result);
        end
      end
    end
    checks++;
    if (mCoinc == 0) begin
      errors++;
      $display("FAIL R8 coincidence seen: got %0d expected above 0", mCoinc);
    end

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule